// File: doc/BRIEF.md
# Line-Synchronous Sound Command Sequencer

This block drives a sound generator from command lists held in memory, with one list per channel and three channels by default. Each horizontal retrace starts a round. In the first phase the sequencer visits the channels in ascending order. Every enabled channel that is not paused reads one 16-bit command word from memory as two byte reads. Once every channel slot has been visited, the second phase runs the captured commands one after another, again in ascending channel order.

The command set covers five operations:
- a sound-register load, which writes to the generator;
- a pause, which skips the channel's next N fetch rounds;
- a repeat/loop pair, which runs the enclosed body N+1 times;
- an interrupt pulse;
- a stop, which disables the channel.

A load lasts at least eight cycles and is stretched while the processor holds the peripheral port. Software starts a channel by pulsing its start bit together with a list address. The address is forced even.

Top module: `dma_cmd_seq`

## Requirements
- R1: A `retrace_i` pulse seen while idle starts a fetch round. Channel slots are visited in ascending order. An enabled, unpaused channel takes two cycles and reads its pointer address, then the pointer address plus one. Any other slot takes one cycle and makes no read.
- R2: A channel start forces address bit 0 to 0. A command word is assembled little-endian: the byte at the even address is bits 7..0 and the next byte is bits 15..8. The pointer advances by 2 per fetched command.
- R3: Execution begins only after the last channel slot has been fetched. Captured commands then run in ascending channel order. Each channel slot in the execute phase takes one cycle, except a load.
- R4: Opcode bits 15..12 select the command. 0 is LOAD: for one cycle it drives `psg_wr_o` with register bits 11..8 and data bits 7..0, and it lasts LOAD_MIN cycles (8). 1 is PAUSE, 2 is REPEAT, 4 is LOOP, 8 is INT and F is STOP. Every other value does nothing for one cycle.
- R5: A LOAD lasts 2 extra cycles when `cpu_psgwr_i` is high in its first cycle. Otherwise it lasts 1 extra cycle when `cpu_ppi_i` is high in that cycle.
- R6: `busy_o` is high from the cycle after the accepted retrace until the round ends. The round's length is the sum of the fetch-slot lengths and the execute-slot lengths.
- R7: REPEAT with argument N (bits 11..0) marks the following command as the loop start. A LOOP returns there while the count is non-zero, decrementing the count each time, so the body runs N+1 times.
- R8: PAUSE with argument N (bits 11..0) makes the channel skip its fetch slot in the next N rounds.
- R9: INT pulses that channel's bit of `irq_o` for the single cycle in which it executes.
- R10: A channel start sets its bit of `ch_en_o`. STOP clears that bit, and the channel no longer fetches.
- R11: A `retrace_i` pulse while `busy_o` is high is ignored.
- R12: After reset, `busy_o`, `ch_en_o`, `irq_o`, `mem_rd_o` and `psg_wr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retrace_i | input | 1 | Horizontal retrace strobe, starts a round |
| ch_start_i | input | NCH | Per-channel start pulse |
| start_addr_i | input | AW | List address loaded on start |
| mem_rd_o | output | 1 | Memory byte read request |
| mem_addr_o | output | AW | Memory byte address |
| mem_data_i | input | 8 | Read byte, valid in the same cycle |
| cpu_ppi_i | input | 1 | Processor is using the peripheral port |
| cpu_psgwr_i | input | 1 | That access is a sound-register write |
| psg_wr_o | output | 1 | Sound-register write strobe |
| psg_reg_o | output | 4 | Sound register number |
| psg_data_o | output | 8 | Sound register data |
| irq_o | output | NCH | Per-channel interrupt pulse |
| ch_en_o | output | NCH | Channel enable state |
| busy_o | output | 1 | Round in progress |

## Verification
The four combinations of the two wait inputs are swept, each with a different register and data value, and the round length is checked against its arithmetic sum. This separates the 0-, 1- and 2-cycle stretch cases and shows that the write strobe takes precedence. Repeat counts 0 to 4 and pause counts 0 to 3 are each checked against the number of writes and the number of skipped rounds, which distinguishes N from N+1 iteration. A mixed three-channel round checks the read address order and the cycle in which each execution effect lands. A second retrace inside a round is checked by confirming that the next round reads the following word rather than skipping one.

// File: rtl/dma_seq_pkg.sv
// Shared command opcodes and sequencer phase type.
// Assumes the opcode sits in bits 15..12 of a 16-bit command word.
package dma_seq_pkg;
    localparam logic [3:0] OP_LOAD   = 4'h0;
    localparam logic [3:0] OP_PAUSE  = 4'h1;
    localparam logic [3:0] OP_REPEAT = 4'h2;
    localparam logic [3:0] OP_LOOP   = 4'h4;
    localparam logic [3:0] OP_INT    = 4'h8;
    localparam logic [3:0] OP_STOP   = 4'hF;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WAIT  = 2'd3
    } phase_e;
endpackage

// File: rtl/dma_load_timer.sv
// Down-counter that stretches a register-load command to its full length.
// Assumes len_i >= 2 whenever start_i is high; last_o marks the final cycle.
module dma_load_timer #(
    parameter int LOAD_MIN = 8,
    parameter int TW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] len_i,
    output logic          last_o
);
    logic [TW-1:0] cnt_q;

    // Load remaining cycles on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= len_i - TW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign last_o = (cnt_q == TW'(1));

    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(LOAD_MIN + 1));
endmodule

// File: rtl/dma_chan_ctx.sv
// Per-channel context: list pointer, captured command, loop and pause state.
// Assumes fetch strobes and exec_i never coincide; start_i wins over all else.
module dma_chan_ctx
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          clr_valid_i,
    input  logic          lo_we_i,
    input  logic          hi_we_i,
    input  logic [7:0]    byte_i,
    input  logic          pause_dec_i,
    input  logic          exec_i,
    output logic [AW-1:0] ptr_o,
    output logic          en_o,
    output logic          paused_o,
    output logic          valid_o,
    output logic [15:0]   cmd_o,
    output logic          irq_o
);
    localparam int ARGW = 12;

    logic [AW-1:0]   ptr_q, loop_ptr_q;
    logic [ARGW-1:0] loop_cnt_q, pause_q;
    logic [15:0]     cmd_q;
    logic            en_q, valid_q;
    logic [3:0]      op;
    logic [ARGW-1:0] arg;

    assign op  = cmd_q[15:12];
    assign arg = cmd_q[ARGW-1:0];

    // Channel state update: start, fetch capture, pause countdown, command effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            loop_ptr_q <= '0;
            loop_cnt_q <= '0;
            pause_q    <= '0;
            cmd_q      <= '0;
            en_q       <= 1'b0;
            valid_q    <= 1'b0;
        end else if (start_i) begin
            ptr_q      <= {start_addr_i[AW-1:1], 1'b0};
            loop_ptr_q <= {start_addr_i[AW-1:1], 1'b0};
            loop_cnt_q <= '0;
            pause_q    <= '0;
            en_q       <= 1'b1;
            valid_q    <= 1'b0;
        end else begin
            if (clr_valid_i)
                valid_q <= 1'b0;
            if (lo_we_i)
                cmd_q[7:0] <= byte_i;
            if (hi_we_i) begin
                cmd_q[15:8] <= byte_i;
                valid_q     <= 1'b1;
                ptr_q       <= ptr_q + AW'(2);
            end
            if (pause_dec_i)
                pause_q <= pause_q - ARGW'(1);
            if (exec_i) begin
                case (op)
                    OP_PAUSE:  pause_q <= arg;
                    OP_REPEAT: begin
                        loop_cnt_q <= arg;
                        loop_ptr_q <= ptr_q;
                    end
                    OP_LOOP: begin
                        if (loop_cnt_q != '0) begin
                            loop_cnt_q <= loop_cnt_q - ARGW'(1);
                            ptr_q      <= loop_ptr_q;
                        end
                    end
                    OP_STOP:   en_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign ptr_o    = ptr_q;
    assign en_o     = en_q;
    assign paused_o = (pause_q != '0);
    assign valid_o  = valid_q;
    assign cmd_o    = cmd_q;
    assign irq_o    = exec_i && (op == OP_INT);

    // R2
    ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[0] == 1'b0);

    // R10
    stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_STOP && !start_i) |=> !en_q);
endmodule

// File: rtl/dma_cmd_seq.sv
// Line-synchronous command sequencer: fetch round then execute round per retrace.
// Assumes mem_data_i reflects mem_addr_o in the same cycle and that the
// wait inputs are meaningful in the first cycle of a load.
module dma_cmd_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int AW       = 16,
    parameter int LOAD_MIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           retrace_i,
    input  logic [NCH-1:0] ch_start_i,
    input  logic [AW-1:0]  start_addr_i,
    output logic           mem_rd_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic [7:0]     mem_data_i,
    input  logic           cpu_ppi_i,
    input  logic           cpu_psgwr_i,
    output logic           psg_wr_o,
    output logic [3:0]     psg_reg_o,
    output logic [7:0]     psg_data_o,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] ch_en_o,
    output logic           busy_o
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TW = $clog2(LOAD_MIN + 3);

    phase_e          phase_q;
    logic [IW-1:0]   idx_q;
    logic            hi_q;

    logic [AW-1:0]   ptr_w [NCH];
    logic [15:0]     cmd_w [NCH];
    logic [NCH-1:0]  en_w, paused_w, valid_w, irq_w;
    logic [NCH-1:0]  lo_we, hi_we, pause_dec, exec_s;

    logic            cur_active, last_slot, fetch_rd, clr_valid, load_go, wait_last;
    logic [15:0]     cur_cmd;
    logic [TW-1:0]   load_len;

    assign cur_active = en_w[idx_q] && !paused_w[idx_q];
    assign cur_cmd    = cmd_w[idx_q];
    assign last_slot  = (idx_q == IW'(NCH - 1));
    assign fetch_rd   = (phase_q == PH_FETCH) && cur_active;
    assign clr_valid  = (phase_q == PH_IDLE) && retrace_i;
    assign load_go    = (phase_q == PH_EXEC) && valid_w[idx_q]
                        && (cur_cmd[15:12] == OP_LOAD);

    // Load length: minimum plus stretch for processor port activity.
    always_comb begin
        load_len = TW'(LOAD_MIN);
        if (cpu_psgwr_i)
            load_len = TW'(LOAD_MIN + 2);
        else if (cpu_ppi_i)
            load_len = TW'(LOAD_MIN + 1);
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign lo_we[g]     = fetch_rd && !hi_q && (idx_q == IW'(g));
            assign hi_we[g]     = fetch_rd &&  hi_q && (idx_q == IW'(g));
            assign pause_dec[g] = (phase_q == PH_FETCH) && (idx_q == IW'(g))
                                  && en_w[g] && paused_w[g];
            assign exec_s[g]    = (phase_q == PH_EXEC) && (idx_q == IW'(g)) && valid_w[g];

            dma_chan_ctx #(.AW(AW)) u_ctx (
                .clk          (clk),
                .rst_n        (rst_n),
                .start_i      (ch_start_i[g]),
                .start_addr_i (start_addr_i),
                .clr_valid_i  (clr_valid),
                .lo_we_i      (lo_we[g]),
                .hi_we_i      (hi_we[g]),
                .byte_i       (mem_data_i),
                .pause_dec_i  (pause_dec[g]),
                .exec_i       (exec_s[g]),
                .ptr_o        (ptr_w[g]),
                .en_o         (en_w[g]),
                .paused_o     (paused_w[g]),
                .valid_o      (valid_w[g]),
                .cmd_o        (cmd_w[g]),
                .irq_o        (irq_w[g])
            );
        end
    endgenerate

    dma_load_timer #(.LOAD_MIN(LOAD_MIN), .TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (load_go),
        .len_i   (load_len),
        .last_o  (wait_last)
    );

    // Round sequencing: idle -> fetch slots -> execute slots (with load waits).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            hi_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (retrace_i) begin
                        phase_q <= PH_FETCH;
                        idx_q   <= '0;
                        hi_q    <= 1'b0;
                    end
                end
                PH_FETCH: begin
                    if (cur_active && !hi_q) begin
                        hi_q <= 1'b1;
                    end else begin
                        hi_q <= 1'b0;
                        if (last_slot) begin
                            phase_q <= PH_EXEC;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end
                end
                PH_EXEC: begin
                    if (load_go)
                        phase_q <= PH_WAIT;
                    else if (last_slot)
                        phase_q <= PH_IDLE;
                    else
                        idx_q <= idx_q + IW'(1);
                end
                default: begin
                    if (wait_last) begin
                        if (last_slot) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_EXEC;
                            idx_q   <= idx_q + IW'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign mem_rd_o   = fetch_rd;
    assign mem_addr_o = ptr_w[idx_q] | AW'(hi_q);
    assign psg_wr_o   = load_go;
    assign psg_reg_o  = cur_cmd[11:8];
    assign psg_data_o = cur_cmd[7:0];
    assign irq_o      = irq_w;
    assign ch_en_o    = en_w;
    assign busy_o     = (phase_q != PH_IDLE);

    // R4
    psg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psg_wr_o |=> !psg_wr_o);

    // R9
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !psg_wr_o && irq_o == '0));

    // R1
    fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_addr_o[0]) |=> (mem_rd_o && mem_addr_o[0]));

    // R11
    retrace_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retrace_i && (phase_q == PH_EXEC || phase_q == PH_WAIT)) |=> phase_q != PH_FETCH);
endmodule

// File: tb/dma_cmd_seq_tb.sv
module dma_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retrace_i = 1'b0;
    logic [2:0]  ch_start_i = '0;
    logic [15:0] start_addr_i = '0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_i;
    logic        cpu_ppi_i = 1'b0, cpu_psgwr_i = 1'b0;
    logic        psg_wr_o;
    logic [3:0]  psg_reg_o;
    logic [7:0]  psg_data_o;
    logic [2:0]  irq_o, ch_en_o;
    logic        busy_o;

    logic [7:0] mem [256];
    int nchk = 0, nfail = 0;
    int busy_n, rd_n, psg_n, psg_at, irq_at;
    logic [7:0] rd_addr [16];
    logic [3:0] last_reg;
    logic [7:0] last_data;
    logic [2:0] irq_mask;
    int cyc_total = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign mem_data_i = mem[mem_addr_o[7:0]];

    dma_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .retrace_i(retrace_i), .ch_start_i(ch_start_i),
        .start_addr_i(start_addr_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_data_i), .cpu_ppi_i(cpu_ppi_i), .cpu_psgwr_i(cpu_psgwr_i),
        .psg_wr_o(psg_wr_o), .psg_reg_o(psg_reg_o), .psg_data_o(psg_data_o),
        .irq_o(irq_o), .ch_en_o(ch_en_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [15:0] w);
        mem[addr]     = w[7:0];
        mem[addr + 1] = w[15:8];
    endtask

    task automatic start(input int ch, input int addr);
        @(negedge clk);
        ch_start_i   = 3'b001 << ch;
        start_addr_i = 16'(addr);
        @(negedge clk);
        ch_start_i   = '0;
    endtask

    // One retrace round; records reads, writes and interrupts per busy cycle.
    task automatic run_line(input bit dbl);
        int cyc;
        @(negedge clk);
        retrace_i = 1'b1;
        @(negedge clk);
        retrace_i = 1'b0;
        cyc = 0; rd_n = 0; psg_n = 0; psg_at = -1; irq_at = -1; irq_mask = '0;
        while (busy_o && cyc < 200) begin
            if (mem_rd_o && rd_n < 16) begin
                rd_addr[rd_n] = mem_addr_o[7:0];
                rd_n++;
            end
            if (psg_wr_o) begin
                psg_n++; psg_at = cyc; last_reg = psg_reg_o; last_data = psg_data_o;
            end
            if (irq_o != '0) begin
                irq_mask = irq_mask | irq_o; irq_at = cyc;
            end
            retrace_i = (dbl && cyc == 3);
            cyc++;
            @(negedge clk);
        end
        retrace_i = 1'b0;
        busy_n = cyc;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000 && !done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(busy_o == 0 && psg_wr_o == 0 && mem_rd_o == 0, "R12 idle outputs", busy_o, 0);
        check(ch_en_o == 0 && irq_o == 0, "R12 enables/irq", ch_en_o, 0);
        rst_n = 1'b1;

        // Mixed three-channel round
        put(8'h10, 16'h035A);
        put(8'h40, 16'h8000);
        put(8'h80, 16'h3000);
        start(0, 8'h10); start(1, 8'h40); start(2, 8'h80);
        check(ch_en_o == 3'b111, "R10 start enables", ch_en_o, 7);
        run_line(0);
        check(rd_n == 6, "R1 read count", rd_n, 6);
        check(rd_addr[0] == 8'h10 && rd_addr[1] == 8'h11 && rd_addr[2] == 8'h40 &&
              rd_addr[3] == 8'h41 && rd_addr[4] == 8'h80 && rd_addr[5] == 8'h81,
              "R1 read order", rd_addr[2], 8'h40);
        check(psg_at == 6, "R3 exec after fetch", psg_at, 6);
        check(psg_n == 1 && last_reg == 4'h3 && last_data == 8'h5A, "R2 R4 LE assembly",
              {last_reg, last_data}, 12'h35A);
        check(irq_mask == 3'b010, "R9 irq channel", irq_mask, 2);
        check(irq_at == 14, "R9 irq cycle", irq_at, 14);
        check(busy_n == 16, "R6 round length", busy_n, 16);

        // Load stretch sweep: all wait-input combinations, twice
        for (int k = 0; k < 8; k++) begin
            put(8'h12 + 2*k, {4'h0, 4'(k + 2), 8'(k*17 + 1)});
            put(8'h42 + 2*k, 16'h3000);
            put(8'h82 + 2*k, 16'h3000);
        end
        for (int k = 0; k < 8; k++) begin
            int len;
            cpu_ppi_i   = k[0];
            cpu_psgwr_i = k[1];
            len = 8 + (k[1] ? 2 : (k[0] ? 1 : 0));
            run_line(0);
            check(busy_n == 6 + len + 2, "R5 stretched load length", busy_n, 6 + len + 2);
            check(psg_n == 1 && last_reg == 4'(k + 2) && last_data == 8'(k*17 + 1),
                  "R4 load fields", {last_reg, last_data}, {4'(k + 2), 8'(k*17 + 1)});
        end
        cpu_ppi_i = 0; cpu_psgwr_i = 0;

        // STOP on every channel, then a round with all slots skipped
        put(8'h22, 16'hF000); put(8'h52, 16'hF000); put(8'h92, 16'hF000);
        run_line(0);
        check(ch_en_o == 3'b000, "R10 stop clears enable", ch_en_o, 0);
        check(busy_n == 9, "R6 stop round length", busy_n, 9);
        run_line(0);
        check(rd_n == 0 && busy_n == 6, "R1 disabled slots skip", busy_n, 6);

        // REPEAT/LOOP sweep
        for (int n = 0; n < 5; n++) begin
            int total, lines;
            put(8'hA0, 16'h2000 | 16'(n));
            put(8'hA2, 16'h0100 | 16'(n));
            put(8'hA4, 16'h4000);
            put(8'hA6, 16'hF000);
            start(0, 8'hA1);
            total = 0; lines = 0;
            run_line(0);
            check(rd_addr[0] == 8'hA0, "R2 odd start forced even", rd_addr[0], 8'hA0);
            lines = 1;
            while (ch_en_o[0] && lines < 40) begin
                run_line(0);
                total += psg_n;
                lines++;
            end
            check(total == n + 1, "R7 body count", total, n + 1);
            check(lines == 2*(n + 1) + 2, "R7 round count", lines, 2*(n + 1) + 2);
        end

        // PAUSE sweep
        for (int n = 0; n < 4; n++) begin
            put(8'hC0, 16'h1000 | 16'(n));
            put(8'hC2, 16'h8000);
            put(8'hC4, 16'hF000);
            start(0, 8'hC0);
            run_line(0);
            for (int j = 0; j < n; j++) begin
                run_line(0);
                check(rd_n == 0 && busy_n == 6, "R8 paused slot skipped", rd_n, 0);
            end
            run_line(0);
            check(irq_mask == 3'b001, "R8 R9 resume after pause", irq_mask, 1);
            run_line(0);
        end

        // Retrace during a busy round
        put(8'hE0, 16'h3000); put(8'hE2, 16'h3000); put(8'hE4, 16'h3000);
        start(0, 8'hE0);
        run_line(1);
        check(rd_n == 2 && busy_n == 7, "R11 single round", busy_n, 7);
        run_line(0);
        check(rd_addr[0] == 8'hE2, "R11 no extra fetch", rd_addr[0], 8'hE2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule